// File: doc/BRIEF.md
# Wired-Remote Key Controller Serial Target

This block is the host-facing serial port of a wired-remote key controller. It runs as an I2C-compatible target, and it samples SCL and SDA on the system clock. A host can write one 8-bit control register. A host can also read a fixed burst of four bytes: a chip identifier, the control register, the type of the last key and the key's duration byte. The block has no register pointer. Every write goes to the control register, and every read starts at the chip identifier.

The 7-bit target address has two parts. The upper five bits are a parameter. The lower two bits come from strap pins. The block acknowledges on SDA with open-drain behaviour: `sda_oe` high pulls the line low. When the duration byte has been sent and the host has acknowledged it, the block pulses `rd_strobe` for one cycle. The key event tracker uses this pulse to retire the key event it reported.

Top module: `keyremote_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI, addr_pins}. Bit 0 of the byte selects the direction: 0 for write, 1 for read. When the address does not match, the block drives nothing until the next START.
- R2: In a write, the first data byte is loaded into `ctrl_reg` and the block acknowledges it.
- R3: Each further data byte in the same write transaction is not acknowledged and leaves `ctrl_reg` unchanged.
- R4: A read returns CHIP_ID, then `ctrl_reg`, then `key_type`, then `key_dur`. Each byte is sent most significant bit first.
- R5: When the host NACKs a byte, the read burst ends. SDA is released, so any further clocks read as ones.
- R6: A STOP releases SDA and returns the block to idle. A repeated START restarts address matching.
- R7: `rd_strobe` is a single-cycle pulse. It fires only after the duration byte has been acknowledged by the host, and never when the host NACKs that byte.
- R8: After reset, `sda_oe` and `rd_strobe` are low and `ctrl_reg` equals CTRL_INIT.
- R9: The block changes `sda_oe` only while the synchronized SCL is low.
- R10: After the fourth byte is acknowledged, the block releases SDA, so any further byte in that burst reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| addr_pins | input | 2 | Strapped low address bits |
| key_type | input | 8 | Key type byte from the key event tracker |
| key_dur | input | 8 | Duration byte: overflow flag and 7-bit time |
| ctrl_reg | output | 8 | Control register |
| rd_strobe | output | 1 | One-cycle pulse when the duration byte has been read and acknowledged |

## Verification
The conditions hardest to reach from the ports are the ones that end a transaction abnormally. These are a second write byte arriving after the control byte, a repeated START that turns a write into a read, and a host that keeps clocking after a NACK or after the fourth byte. The bench reaches each of them by sequencing START, repeated START, STOP and single bits by hand through a bit-level bus model. It then reads the control register back to show that the ignored byte changed nothing. Separate reads that ACK and that NACK the duration byte show whether `rd_strobe` fires.

// File: rtl/keyremote_i2c_target.sv
module keyremote_i2c_target #(
  parameter logic [4:0] ADDR_HI   = 5'b10110,
  parameter logic [7:0] CHIP_ID   = 8'h5E,
  parameter logic [7:0] CTRL_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] addr_pins,
  input  logic [7:0] key_type,
  input  logic [7:0] key_dur,
  output logic [7:0] ctrl_reg,
  output logic       rd_strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_RNEXT
  } state_t;

  state_t     state;
  logic [2:0] scl_q, sda_q;
  logic [2:0] bitcnt, idx;
  logic [6:0] rx;
  logic [7:0] tx, burst_byte;
  logic       rnw, wr_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire scl_rise  = scl_s & ~scl_q[2];
  wire scl_fall  = ~scl_s & scl_q[2];
  wire start_det = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop_det  = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  wire [7:0] rx_byte = {rx, sda_s};
  wire in_wdata = (state == S_WDATA);
  wire in_rack  = (state == S_RACK);

  always_comb
    case (idx)
      3'd1:    burst_byte = ctrl_reg;
      3'd2:    burst_byte = key_type;
      3'd3:    burst_byte = key_dur;
      default: burst_byte = CHIP_ID;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      idx       <= '0;
      rx        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      wr_done   <= 1'b0;
      sda_oe    <= 1'b0;
      ctrl_reg  <= CTRL_INIT;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= 1'b0;
      if (start_det) begin
        state   <= S_ADDR;
        bitcnt  <= '0;
        wr_done <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR:
            if (scl_rise) begin
              rx     <= rx_byte[6:0];
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                if (rx_byte[7:1] == {ADDR_HI, addr_pins}) begin
                  state <= S_AACK;
                  rnw   <= rx_byte[0];
                end else
                  state <= S_IDLE;
              end
            end
          S_AACK:
            if (scl_fall) begin
              bitcnt <= '0;
              if (!sda_oe)
                sda_oe <= 1'b1;
              else if (rnw) begin
                idx    <= '0;
                tx     <= CHIP_ID;
                sda_oe <= ~CHIP_ID[7];
                state  <= S_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WDATA;
              end
            end
          S_WDATA:
            if (scl_rise) begin
              rx     <= rx_byte[6:0];
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7 && !wr_done) begin
                ctrl_reg <= rx_byte;
                wr_done  <= 1'b1;
                state    <= S_WACK;
              end
            end
          S_WACK:
            if (scl_fall) begin
              if (!sda_oe)
                sda_oe <= 1'b1;
              else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= S_WDATA;
              end
            end
          S_RDATA:
            if (scl_fall) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          S_RACK:
            if (scl_rise) begin
              if (!sda_s) begin
                idx       <= idx + 3'd1;
                rd_strobe <= (idx == 3'd3);
                state     <= S_RNEXT;
              end else
                state <= S_IDLE;
            end
          S_RNEXT:
            if (scl_fall) begin
              if (idx == 3'd4)
                state <= S_IDLE;
              else begin
                tx     <= burst_byte;
                sda_oe <= ~burst_byte[7];
                bitcnt <= '0;
                state  <= S_RDATA;
              end
            end
          default: state <= S_IDLE;
        endcase
      end
    end

endmodule

module keyremote_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       sda_oe,
  input logic       stop_det,
  input logic       in_wdata,
  input logic       in_rack,
  input logic [7:0] ctrl_reg,
  input logic       rd_strobe
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));                         // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);                                    // R7
  AST_STROBE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(in_rack) && !$past(sda_s));               // R7
  AST_CTRL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_reg) |-> $past(in_wdata));                      // R2
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);                                        // R6
endmodule

bind keyremote_i2c_target keyremote_i2c_target_chk chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .in_wdata(in_wdata), .in_rack(in_rack),
  .ctrl_reg(ctrl_reg), .rd_strobe(rd_strobe)
);

// File: tb/keyremote_i2c_target_test.sv
module keyremote_i2c_target_test;
  localparam int CLK_P = 10;
  localparam int Q = 10;
  localparam logic [4:0] AHI = 5'b10110;

  logic clk = 0, rst_n = 0, scl = 1, sda_drv = 1;
  logic [1:0] pins = 2'b01;
  logic [7:0] ktype = 8'h3C, kdur = 8'h97;
  logic sda_oe, rd_strobe;
  logic [7:0] ctrl;
  wire sda_line = sda_drv & ~sda_oe;
  int checks = 0, fails = 0, strobes = 0;

  keyremote_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .key_type(ktype), .key_dur(kdur), .ctrl_reg(ctrl),
    .rd_strobe(rd_strobe)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rd_strobe) strobes++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_drv = 1; scl = 1; tick(Q);
    sda_drv = 0; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_drv = 1; tick(Q);
    scl = 1; tick(Q);
    sda_drv = 0; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 0; tick(Q);
    scl = 1; tick(Q);
    sda_drv = 1; tick(Q);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_drv = b; tick(Q);
    scl = 1; tick(Q);
    r = sda_line; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(1'b1, d[i]);
    bit_xfer(~host_ack, r);
  endtask

  task automatic t_reset();
    chk("R8 sda_oe", sda_oe, 0);
    chk("R8 ctrl_reg", ctrl, 8'h00);
    chk("R8 rd_strobe", rd_strobe, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte({AHI, 2'b10, 1'b0}, a);
    chk("R1 mismatched address nack", a, 0);
    send_byte(8'h77, a);
    chk("R1 ignored after mismatch", a, 0);
    bus_stop();
    chk("R1 ctrl untouched", ctrl, 8'h00);
  endtask

  task automatic t_write();
    logic a;
    bus_start();
    send_byte({AHI, 2'b01, 1'b0}, a);
    chk("R1 matched address ack", a, 1);
    send_byte(8'hA5, a);
    chk("R2 control byte ack", a, 1);
    chk("R2 ctrl_reg loaded", ctrl, 8'hA5);
    bus_stop();
  endtask

  task automatic t_read_full();
    logic a; logic [7:0] d; int s0;
    s0 = strobes;
    bus_start();
    send_byte({AHI, 2'b01, 1'b1}, a);
    chk("R1 read address ack", a, 1);
    recv_byte(1, d); chk("R4 chip id", d, 8'h5E);
    recv_byte(1, d); chk("R4 control", d, 8'hA5);
    chk("R7 no strobe before duration", strobes, s0);
    recv_byte(1, d); chk("R4 key type", d, 8'h3C);
    recv_byte(1, d); chk("R4 duration", d, 8'h97);
    chk("R7 one strobe after acked duration", strobes, s0 + 1);
    recv_byte(0, d); chk("R10 byte past burst", d, 8'hFF);
    bus_stop();
    chk("R6 released after stop", sda_oe, 0);
    chk("R7 single strobe overall", strobes, s0 + 1);
  endtask

  task automatic t_extra_write();
    logic a; logic [7:0] d; int s0;
    bus_start();
    send_byte({AHI, 2'b01, 1'b0}, a);
    send_byte(8'h42, a);
    chk("R2 second write ack", a, 1);
    send_byte(8'h99, a);
    chk("R3 extra byte nack", a, 0);
    chk("R3 ctrl unchanged", ctrl, 8'h42);
    bus_stop();
    s0 = strobes;
    bus_start();
    send_byte({AHI, 2'b01, 1'b1}, a);
    recv_byte(1, d); chk("R4 chip id again", d, 8'h5E);
    recv_byte(0, d); chk("R3 readback control", d, 8'h42);
    recv_byte(1, d); chk("R5 released after nack", d, 8'hFF);
    chk("R5 sda_oe low", sda_oe, 0);
    bus_stop();
    chk("R7 no strobe on early nack", strobes, s0);
  endtask

  task automatic t_rstart();
    logic a; logic [7:0] d;
    bus_start();
    send_byte({AHI, 2'b01, 1'b0}, a);
    send_byte(8'h11, a);
    bus_rstart();
    send_byte({AHI, 2'b01, 1'b1}, a);
    chk("R6 repeated start address ack", a, 1);
    recv_byte(1, d); chk("R6 chip id after rstart", d, 8'h5E);
    recv_byte(0, d); chk("R6 control after rstart", d, 8'h11);
    bus_stop();
  endtask

  task automatic t_pins_and_nack();
    logic a; logic [7:0] d; int s0;
    pins = 2'b10;
    ktype = 8'hC3; kdur = 8'h05;
    bus_start();
    send_byte({AHI, 2'b01, 1'b1}, a);
    chk("R1 old strap address nack", a, 0);
    bus_rstart();
    send_byte({AHI, 2'b10, 1'b1}, a);
    chk("R1 new strap address ack", a, 1);
    s0 = strobes;
    recv_byte(1, d);
    recv_byte(1, d);
    recv_byte(1, d); chk("R4 new key type", d, 8'hC3);
    recv_byte(0, d); chk("R4 new duration", d, 8'h05);
    chk("R7 no strobe on nacked duration", strobes, s0);
    bus_stop();
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1;
    tick(5);
    t_mismatch();
    t_write();
    t_read_full();
    t_extra_write();
    t_rstart();
    t_pins_and_nack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule